// File: doc/BRIEF.md
# Host Command Mailbox Port

This block is a byte-wide parallel slave port through which an external host passes command bytes to a local processor and reads status back. The host drives an 8-bit data bus, an active-low chip select, active-low write and read strobes, and a select line. When the select line is high, the host uses the command path. Writes fill a small receive buffer, and reads return a status byte. When the select line is low, the host uses the bulk-data path. Writes land in a single data register, and reads return a byte that software has loaded.

The handshake works as follows. The first command write sets a busy flag, and the busy flag is mirrored into bit 7 of the status byte the host reads. Local software drains the received bytes. It can write a 7-bit software status for the host and then clear busy. Clearing busy also empties the receive buffer, so the next command starts at byte 0. An interrupt line follows busy when two enable bits are both on. The host strobes are asynchronous. Each write strobe is synchronized and edge-detected, and the data is then sampled a programmable 0 to 7 clocks later.

Local register map (3-bit address):
- 0 CTRL: bit0 is the busy interrupt enable, bit1 the port interrupt enable, and bits 6:4 the write sampling delay.
- 1 STAT: bit0 busy, bit1 empty, bit2 overrun, bit3 data-valid. Writing 1 to bit0 clears busy; writing 1 to bit2 clears overrun.
- 2 HSTAT: bits 6:0 hold the software status. A read returns busy in bit 7.
- 3 RXD: a read pops the receive buffer and returns 0 when the buffer is empty.
- 4 DREG: the data-mode byte. A read clears data-valid.
- 5 TXD: the byte returned to host data-mode reads.

Top module: `host_mailbox_port`

## Requirements
- R1: After reset, STAT reads 0x02 (empty only), irq is low, and a host read with select high returns 0x00.
- R2: A host read with select high returns {busy, HSTAT[6:0]}, with busy in bit 7.
- R3: A command-mode host write sets busy (STAT bit0 and host status bit 7).
- R4: irq is high exactly while busy, CTRL bit0 and CTRL bit1 are all set.
- R5: Write data is sampled on the clock edge that is 3+W edges after the first edge that sees the strobe active, where W is CTRL bits 6:4.
- R6: Command bytes are read from RXD in arrival order. STAT bit1 is set when no byte is waiting.
- R7: A command write while 16 bytes are held is dropped and sets STAT bit2. The bit stays set until software writes 1 to it.
- R8: Writing 1 to STAT bit0 clears busy and empties the receive buffer.
- R9: A data-mode host write loads DREG and sets STAT bit3, and a read of DREG clears that bit. A data-mode host read returns TXD.
- R10: One write strobe stores exactly one byte, however long it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| h_cs_n | input | 1 | Host chip select, active low |
| h_wr_n | input | 1 | Host write strobe, active low |
| h_rd_n | input | 1 | Host read strobe, active low |
| h_sel | input | 1 | Host path select: 1 command/status, 0 data |
| h_din | input | 8 | Host write data |
| h_dout | output | 8 | Host read data |
| h_doe | output | 1 | Host data output enable |
| reg_addr | input | 3 | Local register address |
| reg_wr | input | 1 | Local register write strobe |
| reg_rd | input | 1 | Local register read strobe (pops RXD, clears data-valid on DREG) |
| reg_wdata | input | 8 | Local write data |
| reg_rdata | output | 8 | Local read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-byte buffer, a 3-bit delay field and two synchronizer stages. With a 16-byte buffer, the overrun case takes only seventeen host writes. The 3-bit field lets the vector table sweep all eight sampling delays. Two directed writes change the data bus one edge before and one edge after the expected sampling edge, which pins the delay to an exact cycle.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
    localparam int DW = 8;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_STAT  = 3'd1,
        RA_HSTAT = 3'd2,
        RA_RXD   = 3'd3,
        RA_DREG  = 3'd4,
        RA_TXD   = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [2:0] ws;
        logic       port_ie;
        logic       busy_ie;
    } ctrl_t;

    typedef struct packed {
        logic          sel;
        logic [DW-1:0] data;
    } hwr_t;

    localparam int ST_BUSY  = 0;
    localparam int ST_EMPTY = 1;
    localparam int ST_OVR   = 2;
    localparam int ST_DV    = 3;

    function automatic logic [DW-1:0] ctrl_to_byte(ctrl_t c);
        return {1'b0, c.ws, 2'b00, c.port_ie, c.busy_ie};
    endfunction

    function automatic ctrl_t byte_to_ctrl(logic [DW-1:0] b);
        ctrl_t c;
        c.ws      = b[6:4];
        c.port_ie = b[1];
        c.busy_ie = b[0];
        return c;
    endfunction

    function automatic logic [DW-1:0] host_status(logic busy, logic [DW-2:0] sw);
        return {busy, sw};
    endfunction
endpackage

// File: rtl/hmb_sync.sv
module hmb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hmb_wr_sampler.sv
module hmb_wr_sampler
    import hmb_pkg::*;
#(
    parameter int WS_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            h_cs_n,
    input  logic            h_wr_n,
    input  logic            h_sel,
    input  logic [DW-1:0]   h_din,
    input  logic [WS_W-1:0] ws,
    output logic            cap,
    output hwr_t            cap_word
);
    logic            act_raw;
    logic            act_s;
    logic            act_d;
    logic            rise;
    logic [WS_W-1:0] cnt;

    assign act_raw = ~h_cs_n & ~h_wr_n;

    hmb_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (act_raw),
        .q   (act_s)
    );

    assign rise = act_s & ~act_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_d <= 1'b0;
            cnt   <= '0;
        end else begin
            act_d <= act_s;
            if (rise && ws != '0)
                cnt <= ws;
            else if (cnt != '0)
                cnt <= cnt - WS_W'(1);
        end
    end

    assign cap = (rise && ws == '0) || (cnt == WS_W'(1));
    assign cap_word.sel  = h_sel;
    assign cap_word.data = h_din;
endmodule

// File: rtl/hmb_rx_fifo.sv
module hmb_rx_fifo
    import hmb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic                   push,
    input  logic [DW-1:0]          din,
    input  logic                   pop,
    output logic [DW-1:0]          dout,
    output logic                   empty,
    output logic                   full,
    output logic [$clog2(DEPTH):0] count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/host_mailbox_port.sv
module host_mailbox_port
    import hmb_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int WS_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          h_cs_n,
    input  logic          h_wr_n,
    input  logic          h_rd_n,
    input  logic          h_sel,
    input  logic [DW-1:0] h_din,
    output logic [DW-1:0] h_dout,
    output logic          h_doe,
    input  logic [2:0]    reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    localparam int CW = $clog2(DEPTH) + 1;

    ctrl_t         ctrl_q;
    logic          busy_q, ovr_q, dv_q;
    logic [DW-2:0] hsw_q;
    logic [DW-1:0] dreg_q, tx_q;

    logic          cap;
    hwr_t          cap_word;
    logic          fifo_empty, fifo_full;
    logic [CW-1:0] fifo_cnt;
    logic [DW-1:0] fifo_dout;

    logic          wr_stat, busy_clr, ovr_clr, rx_pop, dreg_rd;
    logic          cmd_cap, data_cap;
    reg_addr_e     ra;

    assign ra       = reg_addr_e'(reg_addr);
    assign wr_stat  = reg_wr && ra == RA_STAT;
    assign busy_clr = wr_stat && reg_wdata[ST_BUSY];
    assign ovr_clr  = wr_stat && reg_wdata[ST_OVR];
    assign rx_pop   = reg_rd && ra == RA_RXD;
    assign dreg_rd  = reg_rd && ra == RA_DREG;
    assign cmd_cap  = cap && cap_word.sel;
    assign data_cap = cap && !cap_word.sel;

    hmb_wr_sampler #(.WS_W(WS_W), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .h_cs_n   (h_cs_n),
        .h_wr_n   (h_wr_n),
        .h_sel    (h_sel),
        .h_din    (h_din),
        .ws       (WS_W'(ctrl_q.ws)),
        .cap      (cap),
        .cap_word (cap_word)
    );

    hmb_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (busy_clr),
        .push  (cmd_cap),
        .din   (cap_word.data),
        .pop   (rx_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full),
        .count (fifo_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            busy_q <= 1'b0;
            ovr_q  <= 1'b0;
            dv_q   <= 1'b0;
            hsw_q  <= '0;
            dreg_q <= '0;
            tx_q   <= '0;
        end else begin
            if (reg_wr && ra == RA_CTRL)  ctrl_q <= byte_to_ctrl(reg_wdata);
            if (reg_wr && ra == RA_HSTAT) hsw_q  <= reg_wdata[DW-2:0];
            if (reg_wr && ra == RA_TXD)   tx_q   <= reg_wdata;

            if (busy_clr)     busy_q <= 1'b0;
            else if (cmd_cap) busy_q <= 1'b1;

            if (cmd_cap && fifo_full) ovr_q <= 1'b1;
            else if (ovr_clr)         ovr_q <= 1'b0;

            if (data_cap) begin
                dreg_q <= cap_word.data;
                dv_q   <= 1'b1;
            end else if (dreg_rd) begin
                dv_q   <= 1'b0;
            end
        end
    end

    always_comb begin
        case (ra)
            RA_CTRL:  reg_rdata = ctrl_to_byte(ctrl_q);
            RA_STAT:  reg_rdata = {4'b0000, dv_q, ovr_q, fifo_empty, busy_q};
            RA_HSTAT: reg_rdata = host_status(busy_q, hsw_q);
            RA_RXD:   reg_rdata = fifo_empty ? '0 : fifo_dout;
            RA_DREG:  reg_rdata = dreg_q;
            RA_TXD:   reg_rdata = tx_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign h_doe  = ~h_cs_n & ~h_rd_n;
    assign h_dout = h_sel ? host_status(busy_q, hsw_q) : tx_q;
    assign irq    = busy_q & ctrl_q.busy_ie & ctrl_q.port_ie;
endmodule

// File: rtl/hmb_checker.sv
module hmb_checker #(
    parameter int DEPTH = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   h_cs_n,
    input logic                   h_rd_n,
    input logic                   h_sel,
    input logic [7:0]             h_dout,
    input logic                   busy,
    input logic                   irq,
    input logic                   busy_ie,
    input logic                   port_ie,
    input logic                   ovr,
    input logic                   ovr_clr,
    input logic                   busy_clr,
    input logic                   fifo_empty,
    input logic [$clog2(DEPTH):0] fifo_cnt,
    input logic                   cap,
    input logic                   cap_sel,
    input logic                   dv
);
    assert_busy_mirror_R2: assert property (@(posedge clk) disable iff (rst)
        (!h_cs_n && !h_rd_n && h_sel) |-> (h_dout[7] == busy));

    assert_busy_set_R3: assert property (@(posedge clk) disable iff (rst)
        (cap && cap_sel && !busy_clr) |=> busy);

    assert_irq_gate_R4: assert property (@(posedge clk) disable iff (rst)
        irq |-> (busy && busy_ie && port_ie));

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        32'(fifo_cnt) <= DEPTH);

    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ovr && !ovr_clr) |=> ovr);

    assert_flush_R8: assert property (@(posedge clk) disable iff (rst)
        busy_clr |=> (fifo_empty && !busy));

    assert_data_valid_R9: assert property (@(posedge clk) disable iff (rst)
        (cap && !cap_sel) |=> dv);

    assert_single_capture_R10: assert property (@(posedge clk) disable iff (rst)
        cap |=> !cap);
endmodule

bind host_mailbox_port hmb_checker #(.DEPTH(DEPTH)) u_hmb_checker (
    .clk        (clk),
    .rst        (rst),
    .h_cs_n     (h_cs_n),
    .h_rd_n     (h_rd_n),
    .h_sel      (h_sel),
    .h_dout     (h_dout),
    .busy       (busy_q),
    .irq        (irq),
    .busy_ie    (ctrl_q.busy_ie),
    .port_ie    (ctrl_q.port_ie),
    .ovr        (ovr_q),
    .ovr_clr    (ovr_clr),
    .busy_clr   (busy_clr),
    .fifo_empty (fifo_empty),
    .fifo_cnt   (fifo_cnt),
    .cap        (cap),
    .cap_sel    (cap_word.sel),
    .dv         (dv_q)
);

// File: tb/tb_host_mailbox_port.sv
`timescale 1ns/1ps
module tb_host_mailbox_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       h_cs_n = 1'b1, h_wr_n = 1'b1, h_rd_n = 1'b1, h_sel = 1'b0;
    logic [7:0] h_din = '0;
    logic [7:0] h_dout;
    logic       h_doe;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_HSTAT = 3'd2,
                           A_RXD = 3'd3, A_DREG = 3'd4, A_TXD = 3'd5;

    // {wait code, data byte}
    localparam int NV = 8;
    localparam logic [10:0] VEC [NV] = '{
        {3'd0, 8'h11}, {3'd1, 8'hA2}, {3'd2, 8'h5C}, {3'd3, 8'hFF},
        {3'd4, 8'h00}, {3'd5, 8'h7E}, {3'd6, 8'h81}, {3'd7, 8'h3D}
    };

    always #2.5 clk = ~clk;

    host_mailbox_port dut (
        .clk(clk), .rst(rst), .h_cs_n(h_cs_n), .h_wr_n(h_wr_n), .h_rd_n(h_rd_n),
        .h_sel(h_sel), .h_din(h_din), .h_dout(h_dout), .h_doe(h_doe),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic reg_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic host_write(logic sel, logic [7:0] d, int hold);
        @(negedge clk);
        h_sel = sel; h_din = d; h_cs_n = 1'b0; h_wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        h_wr_n = 1'b1; h_cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic host_read(logic sel, output logic [7:0] d);
        @(negedge clk);
        h_sel = sel; h_cs_n = 1'b0; h_rd_n = 1'b0;
        #1 d = h_dout;
        @(negedge clk);
        h_rd_n = 1'b1; h_cs_n = 1'b1;
    endtask

    // data switches from a to b just after edge k (counted from the strobe)
    task automatic host_write_switch(logic [7:0] a, logic [7:0] b, int k);
        @(negedge clk);
        h_sel = 1'b1; h_din = a; h_cs_n = 1'b0; h_wr_n = 1'b0;
        repeat (k) @(posedge clk);
        #1 h_din = b;
        repeat (12) @(negedge clk);
        h_wr_n = 1'b1; h_cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 0x00 expected 0x01");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_read(A_STAT, r);  check("R1 stat", r, 8'h02);
        check("R1 irq", {7'b0, irq}, 8'h00);
        host_read(1'b1, r);   check("R1 host status", r, 8'h00);

        // Vector table: each wait code, one command byte
        for (int i = 0; i < NV; i++) begin
            reg_write(A_CTRL, {1'b0, VEC[i][10:8], 4'b0000});
            host_write(1'b1, VEC[i][7:0], 14);
            reg_read(A_STAT, r);  check("R3 busy after write", r & 8'h03, 8'h01);
            reg_read(A_RXD, r);   check("R5 data at wait code", r, VEC[i][7:0]);
            reg_write(A_STAT, 8'h01);
            reg_read(A_STAT, r);  check("R8 cleared", r, 8'h02);
        end

        // R5 exact sampling edge: W=3 samples at edge 6
        reg_write(A_CTRL, 8'h30);
        host_write_switch(8'hAA, 8'hBB, 5);
        reg_read(A_RXD, r);   check("R5 switch before edge", r, 8'hBB);
        host_write_switch(8'hCC, 8'hDD, 6);
        reg_read(A_RXD, r);   check("R5 switch after edge", r, 8'hCC);
        reg_write(A_STAT, 8'h01);
        reg_write(A_CTRL, 8'h00);

        // R2 host status format
        reg_write(A_HSTAT, 8'h5A);
        host_read(1'b1, r);   check("R2 idle", r, 8'h5A);
        host_write(1'b1, 8'h01, 10);
        host_read(1'b1, r);   check("R2 busy", r, 8'hDA);
        check("R3 host busy bit", r & 8'h80, 8'h80);

        // R4 interrupt gating
        check("R4 no enables", {7'b0, irq}, 8'h00);
        reg_write(A_CTRL, 8'h01);
        #1 check("R4 one enable", {7'b0, irq}, 8'h00);
        reg_write(A_CTRL, 8'h03);
        #1 check("R4 both enables", {7'b0, irq}, 8'h01);
        reg_write(A_STAT, 8'h01);
        #1 check("R4 busy cleared", {7'b0, irq}, 8'h00);
        reg_write(A_CTRL, 8'h00);

        // R8 flush with bytes pending
        host_write(1'b1, 8'h21, 10);
        host_write(1'b1, 8'h22, 10);
        reg_write(A_STAT, 8'h01);
        reg_read(A_STAT, r);  check("R8 flushed", r, 8'h02);
        host_read(1'b1, r);   check("R8 host bit", r & 8'h80, 8'h00);

        // R6 / R7 ordering and overrun
        for (int i = 0; i < 16; i++) host_write(1'b1, 8'h40 + 8'(i), 10);
        reg_read(A_STAT, r);  check("R7 full no overrun", r & 8'h04, 8'h00);
        host_write(1'b1, 8'hEE, 10);
        reg_read(A_STAT, r);  check("R7 overrun set", r & 8'h04, 8'h04);
        for (int i = 0; i < 16; i++) begin
            reg_read(A_RXD, r); check("R6 order", r, 8'h40 + 8'(i));
        end
        reg_read(A_STAT, r);  check("R6 empty sticky ovr", r, 8'h07);
        reg_write(A_STAT, 8'h04);
        reg_read(A_STAT, r);  check("R7 w1c", r, 8'h03);
        reg_write(A_STAT, 8'h01);

        // R10 long strobe stores once
        host_write(1'b1, 8'h99, 40);
        reg_read(A_RXD, r);   check("R10 byte", r, 8'h99);
        reg_read(A_STAT, r);  check("R10 single", r & 8'h02, 8'h02);
        reg_write(A_STAT, 8'h01);

        // R9 data mode
        host_write(1'b0, 8'h3C, 10);
        reg_read(A_STAT, r);  check("R9 dv set, no busy", r, 8'h0A);
        reg_read(A_DREG, r);  check("R9 dreg", r, 8'h3C);
        reg_read(A_STAT, r);  check("R9 dv cleared", r, 8'h02);
        reg_write(A_TXD, 8'hA5);
        host_read(1'b0, r);   check("R9 tx byte", r, 8'hA5);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule